// File: doc/BRIEF.md
# Restoring Divider with Right-Shifting Divisor

This block divides one unsigned W-bit integer by another over many clock cycles. It uses the restoring method. The remainder accumulator and the divisor register are both 2W bits wide. The dividend enters the lower half of the accumulator. The divisor enters the upper half of its own register and moves one place to the right after every step. Quotient bits enter a W-bit register from the right.

Each iteration takes two cycles. The first cycle makes a trial subtraction of the divisor from the accumulator. The second cycle adds the divisor back if the difference went negative, shifts the new quotient bit in and moves the divisor right. A full division runs W+1 iterations, so its latency is fixed. The first iteration can never produce a 1, and that bit leaves the top of the quotient register.

A zero divisor skips the iterations and raises an error flag. The controller has four states:
- `ST_IDLE` waits for a start pulse.
- `ST_TRIAL` performs the subtraction.
- `ST_SETTLE` performs the restore and the shifts.
- `ST_FINISH` pulses done.

The controller makes these transitions:
- From `ST_IDLE`, start with a nonzero divisor goes to `ST_TRIAL`.
- From `ST_IDLE`, start with a zero divisor goes to `ST_FINISH`.
- `ST_TRIAL` always goes to `ST_SETTLE`.
- `ST_SETTLE` goes back to `ST_TRIAL` while iterations remain, and to `ST_FINISH` after the last one.
- `ST_FINISH` always returns to `ST_IDLE`.

Top module: `rdiv_shift_divisor`

## Requirements
- R1: After reset, busy, done, div_err, quotient and remainder are all 0.
- R2: A start is accepted only in the idle state, where busy and done are both low. Accepting it with a nonzero divisor makes busy high from the next cycle on.
- R3: For a nonzero divisor, quotient equals floor(dividend/divisor) and remainder equals dividend mod divisor. This holds from the done cycle on.
- R4: For a nonzero divisor, done is high only in the cycle after the 2W+3rd rising edge, counting the edge that accepted start. Busy stays high from the accepting edge up to that cycle and is low while done is high. Done is never high for two cycles in a row.
- R5: A zero divisor makes done high right after the accepting edge, with div_err=1, quotient all ones and remainder equal to the dividend.
- R6: div_err is cleared when a start with a nonzero divisor is accepted.
- R7: A start raised while busy or while done is high is ignored. It leaves the running result unchanged, produces no extra done, and does not make busy high.
- R8: Quotient, remainder and div_err hold their values after done until the next accepted start.
- R9: With W=8, dividing 13 by 5 gives quotient 2 and remainder 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division with the present operands |
| dividend | input | W | Unsigned dividend |
| divisor | input | W | Unsigned divisor |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle result-valid pulse |
| div_err | output | 1 | Last accepted division had a zero divisor |
| quotient | output | W | Quotient result |
| remainder | output | W | Remainder result |

## Verification
Timing depends on the divisor:
- A nonzero-divisor result is due in the cycle after the 2W+3rd rising edge, counting the accepting edge.
- A zero-divisor result is due right after the accepting edge.

When the driver raises start, it records the current cycle count plus the expected latency in the scoreboard entry, together with the expected quotient, remainder and error flag. The monitor samples on falling edges. Whenever done is high it pops the oldest entry and compares both the data and the cycle number. Any done that arrives with an empty scoreboard is reported as a spurious completion.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_TRIAL  = 2'd1,
        ST_SETTLE = 2'd2,
        ST_FINISH = 2'd3
    } rdiv_state_e;
endpackage

// File: rtl/rdiv_ctrl.sv
module rdiv_ctrl
    import rdiv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic dvs_zero,
    output logic load,
    output logic load_zero,
    output logic do_trial,
    output logic do_settle,
    output logic busy,
    output logic done,
    output logic div_err
);
    localparam int ITERS = W + 1;
    localparam int CW    = $clog2(ITERS + 1);

    rdiv_state_e     state, nxt;
    logic [CW-1:0]   iter_left;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // iteration counter and error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iter_left <= '0;
            div_err   <= 1'b0;
        end else if (state == ST_IDLE && start) begin
            iter_left <= CW'(ITERS);
            div_err   <= dvs_zero;
        end else if (state == ST_SETTLE) begin
            iter_left <= iter_left - CW'(1);
        end
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = dvs_zero ? ST_FINISH : ST_TRIAL;
            ST_TRIAL:  nxt = ST_SETTLE;
            ST_SETTLE: nxt = (iter_left == CW'(1)) ? ST_FINISH : ST_TRIAL;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load      = 1'b0;
        load_zero = 1'b0;
        do_trial  = 1'b0;
        do_settle = 1'b0;
        busy      = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                load      = start && !dvs_zero;
                load_zero = start &&  dvs_zero;
            end
            ST_TRIAL: begin
                busy     = 1'b1;
                do_trial = 1'b1;
            end
            ST_SETTLE: begin
                busy      = 1'b1;
                do_settle = 1'b1;
            end
            ST_FINISH: done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/rdiv_datapath.sv
module rdiv_datapath #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         load_zero,
    input  logic         do_trial,
    input  logic         do_settle,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         dvs_zero,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int DW = 2 * W;

    logic [DW-1:0] acc;       // partial remainder
    logic [DW-1:0] dvs;       // aligned divisor
    logic          neg;       // last trial went below zero
    logic [DW:0]   diff;

    assign dvs_zero = (divisor == '0);
    assign diff     = {1'b0, acc} - {1'b0, dvs};
    assign rem      = acc[W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
            dvs <= '0;
            quo <= '0;
            neg <= 1'b0;
        end else if (load) begin
            acc <= {{W{1'b0}}, dividend};
            dvs <= {divisor, {W{1'b0}}};
            quo <= '0;
            neg <= 1'b0;
        end else if (load_zero) begin
            acc <= {{W{1'b0}}, dividend};
            quo <= '1;
        end else if (do_trial) begin
            acc <= diff[DW-1:0];
            neg <= diff[DW];
        end else if (do_settle) begin
            if (neg) acc <= acc + dvs;
            quo <= {quo[W-2:0], ~neg};
            dvs <= dvs >> 1;
        end
    end
endmodule

// File: rtl/rdiv_shift_divisor.sv
module rdiv_shift_divisor #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic         div_err,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    logic load, load_zero, do_trial, do_settle, dvs_zero;

    rdiv_ctrl #(.W(W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dvs_zero  (dvs_zero),
        .load      (load),
        .load_zero (load_zero),
        .do_trial  (do_trial),
        .do_settle (do_settle),
        .busy      (busy),
        .done      (done),
        .div_err   (div_err)
    );

    rdiv_datapath #(.W(W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_zero (load_zero),
        .do_trial  (do_trial),
        .do_settle (do_settle),
        .dividend  (dividend),
        .divisor   (divisor),
        .dvs_zero  (dvs_zero),
        .quo       (quotient),
        .rem       (remainder)
    );
endmodule

// File: rtl/rdiv_checker.sv
module rdiv_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] dividend,
    input logic [W-1:0] divisor,
    input logic         busy,
    input logic         done,
    input logic         div_err,
    input logic [W-1:0] quotient,
    input logic [W-1:0] remainder
);
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4

    AST_ACCEPT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done && divisor != '0) |=> (busy && !div_err)); // R2

    AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done && divisor == '0) |=> (done && div_err && quotient == '1)); // R5

    AST_START_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (!busy && !done)); // R7

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ($stable(quotient) && $stable(remainder) && $stable(div_err))); // R8
endmodule

bind rdiv_shift_divisor rdiv_checker #(.W(W)) u_rdiv_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dividend  (dividend),
    .divisor   (divisor),
    .busy      (busy),
    .done      (done),
    .div_err   (div_err),
    .quotient  (quotient),
    .remainder (remainder)
);

// File: tb/test_rdiv_shift_divisor.sv
module test_rdiv_shift_divisor;
    localparam int W   = 8;
    localparam int LAT = 2 * W + 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy, done, div_err;
    logic [W-1:0] quotient, remainder;

    rdiv_shift_divisor #(.W(W)) i_rdiv_shift_divisor (
        .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
        .divisor(divisor), .busy(busy), .done(done), .div_err(div_err),
        .quotient(quotient), .remainder(remainder)
    );

    always #4 clk = ~clk;   // 125 MHz

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [W-1:0] q;
        logic [W-1:0] r;
        logic         e;
        int           due;
        string        tag;
    } exp_t;

    exp_t sb[$];
    int   nvec = 0;
    int   nbad = 0;
    logic prev_done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [W-1:0] a, input logic [W-1:0] d, input string tag);
        exp_t e;
        e.tag = tag;
        if (d == '0) begin
            e.q = '1; e.r = a; e.e = 1'b1; e.due = cyc + 1;
        end else begin
            e.q = a / d; e.r = a % d; e.e = 1'b0; e.due = cyc + LAT;
        end
        sb.push_back(e);
        dividend = a;
        divisor  = d;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
    endtask

    task automatic run(input logic [W-1:0] a, input logic [W-1:0] d, input string tag);
        issue(a, d, tag);
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done) check(!done, "R4", "done longer than one cycle", done, 0);
            if (done) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R7", "spurious done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(cyc == e.due, "R4", {e.tag, " done cycle"}, cyc, e.due);
                    check(quotient == e.q, e.e ? "R5" : "R3", {e.tag, " quotient"}, quotient, e.q);
                    check(remainder == e.r, e.e ? "R5" : "R3", {e.tag, " remainder"}, remainder, e.r);
                    check(div_err == e.e, e.e ? "R5" : "R6", {e.tag, " div_err"}, div_err, e.e);
                    check(!busy, "R4", {e.tag, " busy at done"}, busy, 0);
                end
            end
            prev_done = done;
        end
    end

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !done && !div_err, "R1", "flags after reset", {busy, done, div_err}, 0);
        check(quotient == 0 && remainder == 0, "R1", "results after reset", {quotient, remainder}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run(8'd13, 8'd5, "R9 13/5");
        run(8'd0, 8'd7, "R3 zero dividend");
        run(8'd255, 8'd1, "R3 max by one");
        run(8'd255, 8'd255, "R3 equal");
        run(8'd7, 8'd9, "R3 small dividend");
        run(8'd200, 8'd0, "R5 zero divisor");
        run(8'd100, 8'd3, "R6 after error");
        run(8'd128, 8'd128, "R3 top bit");

        // R2/R7: second start while busy is ignored
        issue(8'd200, 8'd7, "R7 busy poke");
        repeat (4) @(negedge clk);
        check(busy, "R2", "busy during iterations", busy, 1);
        dividend = 8'd9; divisor = 8'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        // R7: start while done is ignored
        dividend = 8'd50; divisor = 8'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!busy && !done, "R7", "start at done ignored", {busy, done}, 0);
        check(quotient == 8'd28 && !div_err, "R7", "result after ignored start", quotient, 28);
        // R8 hold
        repeat (3) @(negedge clk);
        check(quotient == 8'd28, "R8", "quotient held", quotient, 28);
        check(remainder == 8'd4, "R8", "remainder held", remainder, 4);
        check(sb.size() == 0, "R7", "no pending result", sb.size(), 0);

        // R3 pseudo-random operands
        lfsr = 16'hACE1;
        for (int i = 0; i < 24; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            run(lfsr[15:8], lfsr[7:0] >> lfsr[10:8], "R3 random");
        end

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R7", "scoreboard drained", sb.size(), 0);
        finish_run();
    end
endmodule